// File: doc/BRIEF.md
# Burst Data Return Latency Queue

This block sits between a memory command engine and the data bus. Each time the engine issues a read or write burst it pushes a small entry carrying the request tag and the total request size in bytes. An entry may leave the queue only once it has been held for a minimum number of cycles. That minimum is the read (CAS) latency while the bus is in read direction and the write latency while it is in write direction. The direction follows the most recently issued burst.

Every pop stands for one burst on the data bus and credits a fixed number of bytes to the request that owns the entry. When the credited total of a request reaches its size, the block signals completion with that request's tag. A combinational peek output tells the engine whether popping the current head would finish its request. Several multi-burst requests may be interleaved in the queue, and each is tracked separately by its tag.

Top module: `data_lat_queue`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `full_o`=0), the bus is in read direction (`wr_mode_o`=0), and `head_ready_o` and `done_o` are 0.
- R2: The queue holds CAS_LAT+1 entries. `full_o` is 1 when all of them are occupied. A push while `full_o` is 1 is dropped, and the occupancy and the stored entries do not change.
- R3: Entries leave in the order they were pushed.
- R4: In read direction (`wr_mode_o`=0) an entry pushed on clock edge k sets `head_ready_o` only after edge k+CAS_LAT. It may be popped on that edge at the earliest.
- R5: A push with `push_wr_i`=1 sets `wr_mode_o`=1 from the next cycle. From then on the minimum hold is WR_LAT cycles, and this applies to every entry already queued.
- R6: A push with `push_wr_i`=0 sets `wr_mode_o`=0 from the next cycle. From then on the minimum hold is CAS_LAT cycles again.
- R7: `pop_i` has no effect while `head_ready_o` is 0, whether the queue is empty or the head is not yet old enough.
- R8: Each accepted pop adds BURST_BYTES (BURST_LEN×BUS_BYTES, 16 by default) to the returned-byte count of the head's tag. When the new count is at least the head's request size, `done_o` is 1 for exactly the next cycle, with `done_tag_o` equal to that tag, and the count for that tag returns to 0. Otherwise `done_o` stays 0.
- R9: `peek_done_o` is 1 exactly when the queue is non-empty and popping the head would complete its request. `peek_tag_o` shows the head tag. Observing them changes nothing.
- R10: Requests with different tags that are interleaved in the queue accumulate their byte counts independently.
- R11: A push and an accepted pop on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_i | input | 1 | Issue of one burst into the queue |
| push_wr_i | input | 1 | 1 = write burst, 0 = read burst |
| push_tag_i | input | TAG_W | Tag of the request the burst belongs to |
| push_size_i | input | SIZE_W | Total byte size of that request |
| full_o | output | 1 | Queue holds CAS_LAT+1 entries |
| empty_o | output | 1 | Queue holds no entry |
| pop_i | input | 1 | Take one burst off the head |
| head_ready_o | output | 1 | Head entry has met the minimum hold |
| peek_done_o | output | 1 | Popping the head would complete its request |
| peek_tag_o | output | TAG_W | Tag of the head entry |
| done_o | output | 1 | One-cycle completion pulse |
| done_tag_o | output | TAG_W | Tag of the completed request |
| wr_mode_o | output | 1 | Current bus direction, 1 = write |

## Verification
The in-line assertions check the following on every cycle: the occupancy bound, that a push while full leaves the queue full, that no head is ready on an empty queue, that the direction changes only on a push and follows its type, and that every completion pulse follows an accepted pop whose peek said it would complete. The exact hold lengths can only be shown by directed scenarios: CAS_LAT against WR_LAT, the retroactive shortening of an entry's hold when the direction flips, and the tag ordering out of a full queue. Those scenarios also cover per-tag byte accumulation across interleaved requests and the clearing of a count after its request completes.

// File: rtl/dlq_pkg.sv
package dlq_pkg;
  typedef enum logic {
    BUS_RD = 1'b0,
    BUS_WR = 1'b1
  } bus_dir_e;
endpackage

// File: rtl/dlq_dir_ctrl.sv
module dlq_dir_ctrl
  import dlq_pkg::*;
#(
  parameter int CAS_LAT = 5,
  parameter int WR_LAT  = 3,
  parameter int LAT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_fire,
  input  logic             push_wr,
  output bus_dir_e         dir_o,
  output logic [LAT_W-1:0] min_lat_o
);

  bus_dir_e dir_q;
  bus_dir_e dir_d;
  logic     dir_en;

  // next state: every issued burst sets the bus direction
  always_comb begin
    dir_d  = push_wr ? BUS_WR : BUS_RD;
    dir_en = push_fire && (dir_d != dir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= BUS_RD;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  assign dir_o     = dir_q;
  assign min_lat_o = (dir_q == BUS_WR) ? LAT_W'(WR_LAT) : LAT_W'(CAS_LAT);

  // R5
  wr_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && push_wr) |=> (dir_q == BUS_WR));

  // R6
  rd_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !push_wr) |=> (dir_q == BUS_RD));

  // R5
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_fire |=> $stable(dir_q));

endmodule

// File: rtl/dlq_entry_store.sv
module dlq_entry_store #(
  parameter int DEPTH   = 6,
  parameter int TAG_W   = 3,
  parameter int SIZE_W  = 8,
  parameter int LAT_W   = 3,
  parameter int MAX_LAT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_fire,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [SIZE_W-1:0] push_size,
  input  logic              pop_fire,
  input  logic [LAT_W-1:0]  min_lat,
  output logic              full_o,
  output logic              empty_o,
  output logic              head_ready_o,
  output logic [TAG_W-1:0]  head_tag_o,
  output logic [SIZE_W-1:0] head_size_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic [DEPTH-1:0]  valid_vec;
  logic [LAT_W-1:0]  age_arr  [DEPTH];
  logic [TAG_W-1:0]  tag_arr  [DEPTH];
  logic [SIZE_W-1:0] size_arr [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // pointer and occupancy next state
  always_comb begin
    wr_ptr_d = push_fire ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_fire  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    case ({push_fire, pop_fire})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // one slot per entry: valid flag, saturating hold counter, payload
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              slot_wr;
    logic              slot_rd;
    logic              valid_q, valid_d;
    logic [LAT_W-1:0]  age_q, age_d;
    logic              age_en;
    logic [TAG_W-1:0]  tag_q;
    logic [SIZE_W-1:0] size_q;

    always_comb begin
      slot_wr = push_fire && (wr_ptr_q == PTR_W'(g));
      slot_rd = pop_fire  && (rd_ptr_q == PTR_W'(g));
      valid_d = valid_q;
      if (slot_wr) begin
        valid_d = 1'b1;
      end else if (slot_rd) begin
        valid_d = 1'b0;
      end
      age_en = slot_wr || (valid_q && (age_q != LAT_W'(MAX_LAT)));
      age_d  = slot_wr ? '0 : age_q + LAT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        age_q   <= '0;
      end else begin
        valid_q <= valid_d;
        if (age_en) begin
          age_q <= age_d;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (slot_wr) begin
        tag_q  <= push_tag;
        size_q <= push_size;
      end
    end

    assign valid_vec[g] = valid_q;
    assign age_arr[g]   = age_q;
    assign tag_arr[g]   = tag_q;
    assign size_arr[g]  = size_q;
  end

  assign full_o       = (cnt_q == CNT_W'(DEPTH));
  assign empty_o      = (cnt_q == '0);
  assign head_ready_o = valid_vec[rd_ptr_q] && (age_arr[rd_ptr_q] >= min_lat);
  assign head_tag_o   = tag_arr[rd_ptr_q];
  assign head_size_o  = size_arr[rd_ptr_q];

  // R2
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R7
  empty_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> !head_ready_o);

  // R3
  valid_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(valid_vec) == int'(cnt_q));

endmodule

// File: rtl/dlq_byte_track.sv
module dlq_byte_track #(
  parameter int TAG_W       = 3,
  parameter int SIZE_W      = 8,
  parameter int BURST_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_fire,
  input  logic              head_valid,
  input  logic [TAG_W-1:0]  head_tag,
  input  logic [SIZE_W-1:0] head_size,
  output logic              peek_done_o,
  output logic [TAG_W-1:0]  peek_tag_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  done_tag_o
);

  localparam int NTAG  = 1 << TAG_W;
  localparam int BB_W  = $clog2(BURST_BYTES + 1);
  localparam int SUM_W = ((SIZE_W > BB_W) ? SIZE_W : BB_W) + 1;

  logic [SUM_W-1:0] rcv_arr [NTAG];
  logic [SUM_W-1:0] head_sum;
  logic             finish_now;

  logic             done_q, done_d;
  logic [TAG_W-1:0] done_tag_q;

  always_comb begin
    head_sum   = rcv_arr[head_tag] + SUM_W'(BURST_BYTES);
    finish_now = head_sum >= SUM_W'(head_size);
    done_d     = pop_fire && finish_now;
  end

  // one returned-byte counter per tag
  for (genvar g = 0; g < NTAG; g++) begin : g_tag
    logic [SUM_W-1:0] rcv_q, rcv_d;
    logic             rcv_en;

    always_comb begin
      rcv_en = pop_fire && (head_tag == TAG_W'(g));
      rcv_d  = finish_now ? '0 : head_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rcv_q <= '0;
      end else if (rcv_en) begin
        rcv_q <= rcv_d;
      end
    end

    assign rcv_arr[g] = rcv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      done_tag_q <= '0;
    end else begin
      done_q <= done_d;
      if (pop_fire) begin
        done_tag_q <= head_tag;
      end
    end
  end

  assign peek_done_o = head_valid && finish_now;
  assign peek_tag_o  = head_tag;
  assign done_o      = done_q;
  assign done_tag_o  = done_tag_q;

  // R8
  done_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(pop_fire));

  // R9
  peek_predicts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (done_o == $past(peek_done_o)));

  // R8
  done_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && peek_done_o) |=> (done_tag_o == $past(peek_tag_o)));

endmodule

// File: rtl/data_lat_queue.sv
module data_lat_queue
  import dlq_pkg::*;
#(
  parameter int CAS_LAT   = 5,
  parameter int WR_LAT    = 3,
  parameter int TAG_W     = 3,
  parameter int SIZE_W    = 8,
  parameter int BUS_BYTES = 4,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              push_wr_i,
  input  logic [TAG_W-1:0]  push_tag_i,
  input  logic [SIZE_W-1:0] push_size_i,
  output logic              full_o,
  output logic              empty_o,
  input  logic              pop_i,
  output logic              head_ready_o,
  output logic              peek_done_o,
  output logic [TAG_W-1:0]  peek_tag_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  done_tag_o,
  output logic              wr_mode_o
);

  localparam int DEPTH       = CAS_LAT + 1;
  localparam int BURST_BYTES = BUS_BYTES * BURST_LEN;
  localparam int MAX_LAT     = (CAS_LAT > WR_LAT) ? CAS_LAT : WR_LAT;
  localparam int LAT_W       = $clog2(MAX_LAT + 1);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  logic              push_fire;
  logic              pop_fire;
  bus_dir_e          dir;
  logic [LAT_W-1:0]  min_lat;
  logic              full;
  logic              empty;
  logic              head_ready;
  logic [TAG_W-1:0]  head_tag;
  logic [SIZE_W-1:0] head_size;

  assign push_fire = push_i && !full;
  assign pop_fire  = pop_i && head_ready;

  dlq_dir_ctrl #(
    .CAS_LAT (CAS_LAT),
    .WR_LAT  (WR_LAT),
    .LAT_W   (LAT_W)
  ) u_dir (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push_fire (push_fire),
    .push_wr   (push_wr_i),
    .dir_o     (dir),
    .min_lat_o (min_lat)
  );

  dlq_entry_store #(
    .DEPTH   (DEPTH),
    .TAG_W   (TAG_W),
    .SIZE_W  (SIZE_W),
    .LAT_W   (LAT_W),
    .MAX_LAT (MAX_LAT)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .push_fire    (push_fire),
    .push_tag     (push_tag_i),
    .push_size    (push_size_i),
    .pop_fire     (pop_fire),
    .min_lat      (min_lat),
    .full_o       (full),
    .empty_o      (empty),
    .head_ready_o (head_ready),
    .head_tag_o   (head_tag),
    .head_size_o  (head_size)
  );

  dlq_byte_track #(
    .TAG_W       (TAG_W),
    .SIZE_W      (SIZE_W),
    .BURST_BYTES (BURST_BYTES)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .pop_fire    (pop_fire),
    .head_valid  (!empty),
    .head_tag    (head_tag),
    .head_size   (head_size),
    .peek_done_o (peek_done_o),
    .peek_tag_o  (peek_tag_o),
    .done_o      (done_o),
    .done_tag_o  (done_tag_o)
  );

  assign full_o       = full;
  assign empty_o      = empty;
  assign head_ready_o = head_ready;
  assign wr_mode_o    = (dir == BUS_WR);

  // R2
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (full && push_i && !pop_fire) |=> full_o);

  // R7
  pop_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pop_i && !head_ready && !push_fire) |=> $stable(empty_o));

endmodule

// File: tb/sim_data_lat_queue.sv
module sim_data_lat_queue;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       push_i, push_wr_i, pop_i;
  logic [2:0] push_tag_i;
  logic [7:0] push_size_i;
  logic       full_o, empty_o, head_ready_o, peek_done_o, done_o, wr_mode_o;
  logic [2:0] peek_tag_o, done_tag_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  data_lat_queue u0 (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_i), .push_wr_i(push_wr_i), .push_tag_i(push_tag_i),
    .push_size_i(push_size_i), .full_o(full_o), .empty_o(empty_o),
    .pop_i(pop_i), .head_ready_o(head_ready_o), .peek_done_o(peek_done_o),
    .peek_tag_o(peek_tag_o), .done_o(done_o), .done_tag_o(done_tag_o),
    .wr_mode_o(wr_mode_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push1(input logic wr, input logic [2:0] tag, input logic [7:0] sz);
    push_i = 1'b1; push_wr_i = wr; push_tag_i = tag; push_size_i = sz;
    tick();
    push_i = 1'b0;
  endtask

  task automatic pop1();
    pop_i = 1'b1;
    tick();
    pop_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 empty", empty_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 wr_mode", wr_mode_o, 0);
    chk("R1 ready", head_ready_o, 0);
    chk("R1 done", done_o, 0);
  endtask

  // R4 read hold, R9 peek, R8 single-burst completion
  task automatic t_read_lat();
    push1(1'b0, 3'd1, 8'd16);
    chk("R4 ready at age 0", head_ready_o, 0);
    for (int j = 1; j < 5; j++) begin
      tick();
      chk("R4 ready before CAS_LAT", head_ready_o, 0);
      chk("R9 peek stable while waiting", peek_done_o, 1);
    end
    tick();
    chk("R4 ready at CAS_LAT", head_ready_o, 1);
    chk("R9 peek tag", peek_tag_o, 1);
    pop1();
    chk("R8 done", done_o, 1);
    chk("R8 done tag", done_tag_o, 1);
    chk("R3 empty after pop", empty_o, 1);
    tick();
    chk("R8 done one cycle", done_o, 0);
  endtask

  // R5 write hold, R8 two-burst request
  task automatic t_write_lat();
    push1(1'b1, 3'd2, 8'd32);
    chk("R5 wr_mode set", wr_mode_o, 1);
    push1(1'b1, 3'd2, 8'd32);
    tick();
    chk("R5 ready before WR_LAT", head_ready_o, 0);
    tick();
    chk("R5 ready at WR_LAT", head_ready_o, 1);
    chk("R9 peek first burst", peek_done_o, 0);
    pop1();
    chk("R8 no done after first burst", done_o, 0);
    chk("R9 peek second burst", peek_done_o, 1);
    pop1();
    chk("R8 done two bursts", done_o, 1);
    chk("R8 done tag two bursts", done_tag_o, 2);
  endtask

  // R6 read push switches back to CAS_LAT
  task automatic t_read_back();
    push1(1'b0, 3'd5, 8'd16);
    chk("R6 wr_mode cleared", wr_mode_o, 0);
    for (int j = 1; j < 5; j++) begin
      tick();
      chk("R6 ready before CAS_LAT", head_ready_o, 0);
    end
    tick();
    chk("R6 ready at CAS_LAT", head_ready_o, 1);
    pop1();
    chk("R6 done tag", done_tag_o, 5);
  endtask

  // R5 direction change shortens the hold of an already queued entry
  task automatic t_retro();
    push1(1'b0, 3'd6, 8'd16);
    push1(1'b1, 3'd7, 8'd16);
    chk("R5 wr_mode after write", wr_mode_o, 1);
    tick();
    chk("R5 old entry age 2", head_ready_o, 0);
    tick();
    chk("R5 old entry ready at WR_LAT", head_ready_o, 1);
    pop1();
    chk("R5 done tag 6", done_tag_o, 6);
    chk("R5 next ready", head_ready_o, 1);
    pop1();
    chk("R5 done tag 7", done_tag_o, 7);
    chk("R5 done", done_o, 1);
  endtask

  // R7 ignored pops
  task automatic t_ignore();
    pop1();
    chk("R7 pop empty no done", done_o, 0);
    chk("R7 pop empty stays empty", empty_o, 1);
    push1(1'b0, 3'd1, 8'd16);
    pop1();
    chk("R7 early pop no done", done_o, 0);
    chk("R7 early pop keeps entry", empty_o, 0);
    for (int j = 0; j < 4; j++) tick();
    chk("R7 entry ready later", head_ready_o, 1);
    pop1();
    chk("R7 entry intact done", done_o, 1);
    chk("R7 entry intact tag", done_tag_o, 1);
  endtask

  // R2 capacity and dropped push, R3 order
  task automatic t_full();
    push_wr_i = 1'b0; push_size_i = 8'd16;
    for (int t = 0; t < 6; t++) begin
      push_i = 1'b1; push_tag_i = 3'(t);
      tick();
    end
    push_i = 1'b0;
    chk("R2 full at CAS_LAT+1", full_o, 1);
    push1(1'b0, 3'd7, 8'd16);
    chk("R2 still full", full_o, 1);
    pop_i = 1'b1;
    for (int t = 0; t < 6; t++) begin
      tick();
      chk("R3 done each pop", done_o, 1);
      chk("R3 order", done_tag_o, t);
    end
    pop_i = 1'b0;
    chk("R2 dropped push not stored", empty_o, 1);
  endtask

  // R10 interleaved tags
  task automatic t_interleave();
    push1(1'b0, 3'd3, 8'd32);
    push1(1'b0, 3'd4, 8'd16);
    push1(1'b0, 3'd3, 8'd32);
    for (int j = 0; j < 3; j++) tick();
    pop_i = 1'b1;
    tick();
    chk("R10 tag3 first burst no done", done_o, 0);
    tick();
    chk("R10 tag4 done", done_o, 1);
    chk("R10 tag4 tag", done_tag_o, 4);
    tick();
    pop_i = 1'b0;
    chk("R10 tag3 done", done_o, 1);
    chk("R10 tag3 tag", done_tag_o, 3);
  endtask

  // R11 push with pop, R8 count cleared after completion
  task automatic t_simul();
    push1(1'b0, 3'd1, 8'd16);
    for (int j = 0; j < 5; j++) tick();
    push_i = 1'b1; push_wr_i = 1'b0; push_tag_i = 3'd2; push_size_i = 8'd32;
    pop_i = 1'b1;
    tick();
    push_i = 1'b0; pop_i = 1'b0;
    chk("R11 pop done", done_o, 1);
    chk("R11 pop tag", done_tag_o, 1);
    chk("R11 push kept", empty_o, 0);
    chk("R11 new entry not ready", head_ready_o, 0);
    for (int j = 0; j < 5; j++) tick();
    chk("R8 cleared count peek", peek_done_o, 0);
    pop1();
    chk("R8 cleared count no done", done_o, 0);
    chk("R8 empty after", empty_o, 1);
  endtask

  initial begin
    rst_n = 1'b0; push_i = 1'b0; push_wr_i = 1'b0; pop_i = 1'b0;
    push_tag_i = '0; push_size_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_read_lat();
    t_write_lat();
    t_read_back();
    t_retro();
    t_ignore();
    t_full();
    t_interleave();
    t_simul();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule